// File: doc/BRIEF.md
# Master Timer Trigger Output Selector

This block picks the one signal that a master timer passes on to slave timers or converters. A 4-bit mode register chooses the source. Some sources are one-cycle events: the software update strobe, the update event, and the channel-1 capture/compare event. The others are levels: counter enable, the four compare reference levels, and the encoder clock. The chosen source is registered, so the trigger output follows it one clock later.

The encoder-clock source is only meaningful while the slave controller runs an encoder-style mode. The block therefore watches the current slave-mode code. If the encoder source is chosen while the slave-mode code is not on the permitted list, the block holds the trigger low and raises an error flag. Mode codes above the encoder code are reserved and give a low trigger. The counter, the channels and the slave controller all live outside this block.

Top module: `master_trig_sel`

## Requirements
- R1: A synchronous active-low reset sets the mode register to 0 (software-strobe source) and drives `trig_o` and `enc_err_o` low.
- R2: When `mode_wr_i` is high at a clock edge, `mode_wdata_i` is stored at that edge. The new mode selects the source from the next edge on; the edge that performs the write still uses the old mode.
- R3: In mode 0, `trig_o` equals the value `sw_upd_i` had at the previous clock edge.
- R4: In mode 1, `trig_o` equals the value `cnt_en_i` had at the previous clock edge.
- R5: In mode 2, `trig_o` equals the value `upd_evt_i` had at the previous clock edge.
- R6: In mode 3, every cycle in which `cc1_evt_i` is high gives one cycle of high `trig_o` one clock later. Back-to-back events each count, so they keep the output high on each following cycle.
- R7: In modes 4, 5, 6 and 7, `trig_o` follows bits 0, 1, 2 and 3 of `oc_ref_i` respectively, one clock late.
- R8: In mode 8, when `slave_mode_i` is 1, 2, 3, 10, 11, 12, 13, 14 or 15, `trig_o` follows `enc_clk_i` one clock late and `enc_err_o` is low.
- R9: In mode 8, when `slave_mode_i` is 0, 4, 5, 6, 7, 8 or 9, `trig_o` is low and `enc_err_o` is high one clock later.
- R10: In modes 9 to 15, `trig_o` and `enc_err_o` are low whatever the source inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 4 | New mode value |
| sw_upd_i | input | 1 | Software update-generation strobe |
| cnt_en_i | input | 1 | Counter-enable level |
| upd_evt_i | input | 1 | Update event strobe |
| cc1_evt_i | input | 1 | Channel-1 capture/compare event strobe |
| oc_ref_i | input | 4 | Compare reference levels, bit n is channel n+1 |
| enc_clk_i | input | 1 | Encoder clock |
| slave_mode_i | input | 4 | Current slave-mode code |
| trig_o | output | 1 | Registered trigger output |
| enc_err_o | output | 1 | Encoder source chosen with a disallowed slave-mode code |

## Verification
The hardest case to reach is the encoder mode with each of the sixteen slave-mode codes, while the encoder clock keeps toggling. Only then does a wrongly admitted or wrongly rejected code show up as a difference in the output. The bench sits in mode 8 and sweeps every slave-mode code, holding each for several toggling cycles. It also writes the mode in the same cycle a strobe arrives, which shows the one-cycle hand-over between the old and new mode.

// File: rtl/mts_pkg.sv
// Package: shared mode codes and the encoder permission rule for the
// master trigger selector. Assumes 4-bit mode and slave-mode codes.
package mts_pkg;

    localparam int MODE_W = 4;
    localparam int SLV_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        SRC_SWUPD = 4'd0,
        SRC_CNTEN = 4'd1,
        SRC_UPD   = 4'd2,
        SRC_CC1   = 4'd3,
        SRC_OC1   = 4'd4,
        SRC_OC2   = 4'd5,
        SRC_OC3   = 4'd6,
        SRC_OC4   = 4'd7,
        SRC_ENC   = 4'd8
    } src_mode_e;

    // Returns 1 when the slave-mode code permits the encoder clock source.
    function automatic logic enc_code_ok(input logic [SLV_W-1:0] code);
        case (code)
            4'd1, 4'd2, 4'd3,
            4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: enc_code_ok = 1'b1;
            default:                                   enc_code_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mts_mode_reg.sv
// Mode register: holds the source-select code.
// Assumes a single-cycle write strobe. Reset value selects the software strobe.
module mts_mode_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mode_o
);

    // Store a new mode on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_o <= '0;
        else if (wr_i)
            mode_o <= wdata_i;
    end

endmodule

// File: rtl/mts_enc_guard.sv
// Encoder guard: decides whether the encoder source is usable and whether
// choosing it is an error. Purely combinational. Assumes the mode input is
// already registered.
module mts_enc_guard
    import mts_pkg::*;
#(
    parameter int W  = 4,
    parameter int SW = 4
) (
    input  logic [W-1:0]  mode_i,
    input  logic [SW-1:0] slave_mode_i,
    output logic          enc_pass_o,
    output logic          enc_bad_o
);

    logic enc_sel;
    logic code_ok;

    // Detect the encoder mode and check the slave code against the allowed set.
    always_comb begin
        enc_sel    = (mode_i == W'(SRC_ENC));
        code_ok    = enc_code_ok(SLV_W'(slave_mode_i));
        enc_pass_o = enc_sel & code_ok;
        enc_bad_o  = enc_sel & ~code_ok;
    end

endmodule

// File: rtl/mts_src_mux.sv
// Source multiplexer: picks the next trigger value from the event strobes
// and level sources according to the mode. Reserved codes give 0.
// Assumes compare channels occupy codes OC_BASE .. OC_BASE+NUM_OC-1.
module mts_src_mux
    import mts_pkg::*;
#(
    parameter int W      = 4,
    parameter int NUM_OC = 4
) (
    input  logic [W-1:0]      mode_i,
    input  logic              sw_upd_i,
    input  logic              cnt_en_i,
    input  logic              upd_evt_i,
    input  logic              cc1_evt_i,
    input  logic [NUM_OC-1:0] oc_ref_i,
    input  logic              enc_clk_i,
    input  logic              enc_pass_i,
    output logic              next_o
);

    localparam int OC_BASE = int'(SRC_OC1);

    logic [NUM_OC-1:0] oc_hit;

    // One decode term per compare channel.
    for (genvar g = 0; g < NUM_OC; g++) begin : g_oc
        assign oc_hit[g] = (mode_i == W'(OC_BASE + g)) & oc_ref_i[g];
    end

    // Select the source for the next trigger value.
    always_comb begin
        case (mode_i)
            W'(SRC_SWUPD): next_o = sw_upd_i;
            W'(SRC_CNTEN): next_o = cnt_en_i;
            W'(SRC_UPD):   next_o = upd_evt_i;
            W'(SRC_CC1):   next_o = cc1_evt_i;
            W'(SRC_ENC):   next_o = enc_clk_i & enc_pass_i;
            default:       next_o = |oc_hit;
        endcase
    end

endmodule

// File: rtl/master_trig_sel.sv
// Master trigger selector top: mode register, source mux, encoder guard and
// output registers. The output and error flag lag their sources by one cycle.
// Assumes all inputs are synchronous to clk.
module master_trig_sel #(
    parameter int NUM_OC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_i,
    input  logic [3:0]        mode_wdata_i,
    input  logic              sw_upd_i,
    input  logic              cnt_en_i,
    input  logic              upd_evt_i,
    input  logic              cc1_evt_i,
    input  logic [NUM_OC-1:0] oc_ref_i,
    input  logic              enc_clk_i,
    input  logic [3:0]        slave_mode_i,
    output logic              trig_o,
    output logic              enc_err_o
);

    localparam int W  = mts_pkg::MODE_W;
    localparam int SW = mts_pkg::SLV_W;

    logic [W-1:0] mode_q;
    logic         enc_pass;
    logic         enc_bad;
    logic         trig_d;

    mts_mode_reg #(.W(W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mode_wr_i),
        .wdata_i (mode_wdata_i),
        .mode_o  (mode_q)
    );

    mts_enc_guard #(.W(W), .SW(SW)) u_guard (
        .mode_i       (mode_q),
        .slave_mode_i (slave_mode_i),
        .enc_pass_o   (enc_pass),
        .enc_bad_o    (enc_bad)
    );

    mts_src_mux #(.W(W), .NUM_OC(NUM_OC)) u_mux (
        .mode_i     (mode_q),
        .sw_upd_i   (sw_upd_i),
        .cnt_en_i   (cnt_en_i),
        .upd_evt_i  (upd_evt_i),
        .cc1_evt_i  (cc1_evt_i),
        .oc_ref_i   (oc_ref_i),
        .enc_clk_i  (enc_clk_i),
        .enc_pass_i (enc_pass),
        .next_o     (trig_d)
    );

    // Register the trigger and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o    <= 1'b0;
            enc_err_o <= 1'b0;
        end else begin
            trig_o    <= trig_d;
            enc_err_o <= enc_bad;
        end
    end

endmodule

// File: rtl/master_trig_sel_chk.sv
// Checker for master_trig_sel: relates the registered outputs to the mode
// and source inputs of the previous cycle. Bound into the top module.
module master_trig_sel_chk #(
    parameter int NUM_OC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mode_q,
    input logic              sw_upd_i,
    input logic              cnt_en_i,
    input logic              upd_evt_i,
    input logic              cc1_evt_i,
    input logic [NUM_OC-1:0] oc_ref_i,
    input logic              enc_clk_i,
    input logic [3:0]        slave_mode_i,
    input logic              trig_o,
    input logic              enc_err_o
);
    import mts_pkg::*;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!trig_o && !enc_err_o));

    // R3
    swupd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'd0) |=> (trig_o == $past(sw_upd_i)));

    // R4
    cnten_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'd1) |=> (trig_o == $past(cnt_en_i)));

    // R5
    upd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'd2) |=> (trig_o == $past(upd_evt_i)));

    // R6
    cc1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'd3 && cc1_evt_i) |=> trig_o);

    // R7
    ocref_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:2] == 2'b01) |=> (trig_o == $past(oc_ref_i[mode_q[1:0]])));

    // R8
    enc_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'd8 && enc_code_ok(slave_mode_i))
        |=> (trig_o == $past(enc_clk_i) && !enc_err_o));

    // R9
    enc_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'd8 && !enc_code_ok(slave_mode_i)) |=> (!trig_o && enc_err_o));

    // R10
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q > 4'd8) |=> (!trig_o && !enc_err_o));

endmodule

bind master_trig_sel master_trig_sel_chk #(.NUM_OC(NUM_OC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .sw_upd_i     (sw_upd_i),
    .cnt_en_i     (cnt_en_i),
    .upd_evt_i    (upd_evt_i),
    .cc1_evt_i    (cc1_evt_i),
    .oc_ref_i     (oc_ref_i),
    .enc_clk_i    (enc_clk_i),
    .slave_mode_i (slave_mode_i),
    .trig_o       (trig_o),
    .enc_err_o    (enc_err_o)
);

// File: tb/master_trig_sel_tb.sv
module master_trig_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic       sw_upd = 1'b0, cnt_en = 1'b0, upd_evt = 1'b0, cc1_evt = 1'b0;
    logic [3:0] oc_ref = '0;
    logic       enc_clk = 1'b0;
    logic [3:0] slave_mode = '0;
    logic       trig, enc_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_mode = 0;
    bit e_trig = 0, e_err = 0;
    string e_req = "R1";
    bit extra_req_set = 0;
    string extra_req = "";

    master_trig_sel u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_i    (mode_wr),
        .mode_wdata_i (mode_wdata),
        .sw_upd_i     (sw_upd),
        .cnt_en_i     (cnt_en),
        .upd_evt_i    (upd_evt),
        .cc1_evt_i    (cc1_evt),
        .oc_ref_i     (oc_ref),
        .enc_clk_i    (enc_clk),
        .slave_mode_i (slave_mode),
        .trig_o       (trig),
        .enc_err_o    (enc_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit slave_allowed(int c);
        return (c >= 1 && c <= 3) || (c >= 10 && c <= 15);
    endfunction

    // Behavioural model: evaluates the edge just passed, then compares.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_mode = 0; e_trig = 0; e_err = 0; e_req = "R1";
        end else begin
            e_err = 0;
            if (m_mode == 0) begin e_trig = sw_upd;  e_req = "R3"; end
            else if (m_mode == 1) begin e_trig = cnt_en;  e_req = "R4"; end
            else if (m_mode == 2) begin e_trig = upd_evt; e_req = "R5"; end
            else if (m_mode == 3) begin e_trig = cc1_evt; e_req = "R6"; end
            else if (m_mode >= 4 && m_mode <= 7) begin
                e_trig = oc_ref[m_mode-4]; e_req = "R7";
            end else if (m_mode == 8) begin
                if (slave_allowed(slave_mode)) begin e_trig = enc_clk; e_req = "R8"; end
                else begin e_trig = 0; e_err = 1; e_req = "R9"; end
            end else begin e_trig = 0; e_req = "R10"; end
            if (mode_wr) m_mode = mode_wdata;
        end
        if (extra_req_set) e_req = {e_req, "/", extra_req};
        checks++;
        if (trig !== e_trig) begin
            fails++;
            $display("FAIL %s trig_o actual=%b expected=%b at %0t", e_req, trig, e_trig, $time);
        end
        checks++;
        if (enc_err !== e_err) begin
            fails++;
            $display("FAIL %s enc_err_o actual=%b expected=%b at %0t", e_req, enc_err, e_err, $time);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic set_mode(int m);
        mode_wr = 1; mode_wdata = 4'(m);
        step();
        mode_wr = 0;
    endtask

    task automatic idle_src();
        sw_upd = 0; cnt_en = 0; upd_evt = 0; cc1_evt = 0; oc_ref = '0; enc_clk = 0;
    endtask

    initial begin : stim
        int lfsr = 32'h1ACE;
        // R1: reset state, held for several cycles with sources active
        sw_upd = 1; cnt_en = 1;
        step(3);
        rst_n = 1;
        // R1: after reset, mode 0 selects the software strobe (R3)
        sw_upd = 0; step(); sw_upd = 1; step(); sw_upd = 0; step(2);
        // R3: pulse patterns in mode 0
        for (int i = 0; i < 20; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            sw_upd = lfsr[0]; cnt_en = lfsr[1]; upd_evt = lfsr[2]; step();
        end
        idle_src();
        // R4: counter enable level
        set_mode(1);
        cnt_en = 1; step(4); cnt_en = 0; step(2); cnt_en = 1; step(); cnt_en = 0; step();
        // R2: write in the same cycle as an update strobe; old mode (1) still rules
        extra_req_set = 1; extra_req = "R2";
        mode_wr = 1; mode_wdata = 4'd2; upd_evt = 1; cnt_en = 0; step();
        mode_wr = 0; upd_evt = 1; step(); upd_evt = 0; step();
        extra_req_set = 0;
        // R5: update event strobes
        for (int i = 0; i < 12; i++) begin upd_evt = (i % 3 == 0); step(); end
        upd_evt = 0;
        // R6: isolated and back-to-back channel-1 events
        set_mode(3);
        cc1_evt = 1; step(); cc1_evt = 0; step(2);
        cc1_evt = 1; step(3); cc1_evt = 0; step(2);
        // R7: each compare reference, walking bits
        for (int m = 4; m <= 7; m++) begin
            set_mode(m);
            for (int b = 0; b < 8; b++) begin oc_ref = 4'(1 << (b % 4)); step(); end
            oc_ref = 4'hF; step(); oc_ref = '0; step();
        end
        // R8 and R9: every slave-mode code with a toggling encoder clock
        set_mode(8);
        for (int s = 0; s < 16; s++) begin
            slave_mode = 4'(s);
            for (int k = 0; k < 6; k++) begin enc_clk = ~enc_clk; sw_upd = 1; step(); end
        end
        idle_src(); slave_mode = 4'd1;
        // R10: reserved codes with all sources high
        for (int m = 9; m <= 15; m++) begin
            set_mode(m);
            sw_upd = 1; cnt_en = 1; upd_evt = 1; cc1_evt = 1; oc_ref = 4'hF;
            for (int k = 0; k < 4; k++) begin enc_clk = ~enc_clk; step(); end
            idle_src();
        end
        // R1: reset mid-run from encoder error state clears mode back to 0
        slave_mode = 4'd0; set_mode(8); step(2);
        rst_n = 0; step(2); rst_n = 1;
        upd_evt = 1; sw_upd = 0; step(); sw_upd = 1; step(); idle_src(); step(2);
        done = 1;
    end

    initial begin : finish_ctl
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        @(negedge clk); #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule